// File: doc/BRIEF.md
# Bus-write block packer for a hashing stream

This block is a bus slave on an AHB-Lite interface. It owns a 2 KiB input window at 0x6001_0000. It turns 32-bit word writes into that window into 512-bit blocks on a valid/ready stream for a downstream hash core. Sixteen accepted words make one block. The first word of a block lands in the most significant lane, and each later word fills the next lane down.

Packets are placed in the window so that their final word falls on the top word of the window. A software writer places a packet of N blocks at the window base plus 0x800 minus 0x40·N. The block that completes on the top-word address is flagged as the last block of its packet. No separate end-of-packet register is needed.

A completed block waits until the consumer takes it. If another write arrives before that, the slave inserts wait states, so no word is lost. The block also drives a constant configuration stream toward the hash core: a 512-bit message size, scheme 0, last set and valid held high. It runs on the bus clock and the active-low bus reset.

Top module: `ahb_block_packer`

## Requirements
- R1: During and directly after reset, hreadyout_o is 1, hresp_o is 0 (OKAY) and blk_valid_o is 0.
- R2: Sixteen accepted word writes form one block. The k-th accepted word (k = 0..15) sits in blk_data_o[511-32k -: 32], so the first word is in bits [511:480].
- R3: blk_valid_o rises in the cycle after the data phase of the 16th accepted word. It then stays high with blk_data_o and blk_last_o unchanged until a cycle in which blk_ready_i is 1. It is low in the cycle after that handshake.
- R4: blk_last_o is 1 exactly when the 16th word of the block was written at address 0x6001_07FC, the top word of the window. Otherwise it is 0.
- R5: While blk_valid_o is 1 and blk_ready_i is 0, a write in its data phase drives hreadyout_o to 0. The word is taken in the handshake cycle as word 0 of the next block.
- R6: A read of the window completes with hrdata_o = 0, hresp_o = 0 and no wait state, and it does not count as a word.
- R7: A transfer is ignored, with no word counted, when any of the following holds: hsel_i is 0; htrans_i is IDLE (00) or BUSY (01); hsize_i is not 2 (32-bit); the address is outside [0x6001_0000, 0x6001_0800); or haddr_i[1:0] is not 0. A write is accepted only for NONSEQ (10) or SEQ (11).
- R8: The configuration outputs are constant: cfg_size_o = 512 (64 bits), cfg_scheme_o = 0, cfg_last_o = 1 and cfg_valid_o = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Active-low asynchronous bus reset |
| hsel_i | input | 1 | Slave select |
| haddr_i | input | 32 | Transfer address |
| htrans_i | input | 2 | Transfer type |
| hwrite_i | input | 1 | 1 = write |
| hsize_i | input | 3 | Transfer size |
| hwdata_i | input | 32 | Write data |
| hready_i | input | 1 | Bus-level ready (previous transfer done) |
| hreadyout_o | output | 1 | Slave ready; 0 inserts wait states |
| hresp_o | output | 1 | Response, always OKAY |
| hrdata_o | output | 32 | Read data, always zero |
| blk_data_o | output | 512 | Assembled block |
| blk_last_o | output | 1 | Block is final of its packet |
| blk_valid_o | output | 1 | Block available |
| blk_ready_i | input | 1 | Consumer accepts the block |
| cfg_size_o | output | 64 | Constant message size |
| cfg_scheme_o | output | 2 | Constant scheme select |
| cfg_last_o | output | 1 | Constant last flag |
| cfg_valid_o | output | 1 | Constant valid |

## Verification
A wrong word count shows one cycle after the data phase where a block should close. blk_valid_o then rises early or late, or every later block has its lanes shifted. The bench therefore checks valid both before and right after the 16th word, and checks the full 512-bit value. A stuck top-address latch shows as a wrong blk_last_o on the block's first valid cycle. A failed stall shows at once as hreadyout_o high during a blocked write, or as a changed block before the handshake. Ignored transfers that get counted anyway show up as an early valid or misplaced lanes on the very next block.

// File: rtl/blkpack_pkg.sv
package blkpack_pkg;
  typedef enum logic [1:0] {
    TR_IDLE   = 2'b00,
    TR_BUSY   = 2'b01,
    TR_NONSEQ = 2'b10,
    TR_SEQ    = 2'b11
  } htrans_e;

  localparam int unsigned DEF_ADDR_W = 32;
  localparam int unsigned DEF_DATA_W = 32;
  localparam int unsigned DEF_BLK_W  = 512;
endpackage

// File: rtl/ahb_wr_front.sv
module ahb_wr_front
  import blkpack_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 32'h6001_0000,
  parameter logic [ADDR_W-1:0] WIN_BYTES = 32'h0000_0800
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hsel_i,
  input  logic [ADDR_W-1:0] haddr_i,
  input  logic [1:0]        htrans_i,
  input  logic              hwrite_i,
  input  logic [2:0]        hsize_i,
  input  logic              hready_i,
  input  logic              stall_i,
  output logic              hreadyout_o,
  output logic              wr_en_o,
  output logic              wr_top_o
);
  localparam int unsigned BYTES   = DATA_W / 8;
  localparam int unsigned ALIGN_W = $clog2(BYTES);
  localparam logic [2:0]  WSIZE   = 3'(ALIGN_W);
  localparam logic [ADDR_W-1:0] TOP_ADDR = BASE_ADDR + WIN_BYTES - ADDR_W'(BYTES);

  htrans_e           trans;
  logic              active, in_win, aligned, take;
  logic [ADDR_W-1:0] offs;
  logic              dp_wr_q, dp_top_q;

  assign trans   = htrans_e'(htrans_i);
  assign active  = (trans == TR_NONSEQ) || (trans == TR_SEQ);
  assign offs    = haddr_i - BASE_ADDR;
  assign in_win  = offs < WIN_BYTES;
  assign aligned = haddr_i[ALIGN_W-1:0] == '0;
  assign take    = hsel_i && active && hwrite_i && (hsize_i == WSIZE) && in_win && aligned;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dp_wr_q  <= 1'b0;
      dp_top_q <= 1'b0;
    end else if (hready_i) begin
      dp_wr_q  <= take;
      dp_top_q <= take && (haddr_i == TOP_ADDR);
    end
  end

  assign hreadyout_o = !(dp_wr_q && stall_i);
  assign wr_en_o     = dp_wr_q && !stall_i;
  assign wr_top_o    = dp_top_q;

  AST_IGNORE_SIZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hready_i && (hsize_i != WSIZE) |=> !dp_wr_q); // R7
  AST_IGNORE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hready_i && !active |=> !dp_wr_q); // R7
  AST_READ_NOCOUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hready_i && !hwrite_i |=> !wr_en_o); // R6
endmodule

// File: rtl/blk_word_packer.sv
module blk_word_packer #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned BLK_W  = 512
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              wr_top_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              blk_ready_i,
  output logic [BLK_W-1:0]  blk_data_o,
  output logic              blk_last_o,
  output logic              blk_valid_o,
  output logic              stall_o
);
  localparam int unsigned WORDS = BLK_W / DATA_W;
  localparam int unsigned CNT_W = $clog2(WORDS + 1);

  logic [BLK_W-1:0] buf_q, buf_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             valid_q, valid_n, last_q, last_n, hshake;

  assign hshake = valid_q && blk_ready_i;

  always_comb begin
    buf_n   = hshake ? '0 : buf_q;
    cnt_n   = hshake ? '0 : cnt_q;
    valid_n = valid_q && !hshake;
    last_n  = hshake ? 1'b0 : last_q;
    if (wr_en_i) begin
      // lane by arrival order, top lane first
      for (int k = 0; k < WORDS; k++) begin
        if (CNT_W'(k) == cnt_n) buf_n[BLK_W-1-DATA_W*k -: DATA_W] = wr_data_i;
      end
      cnt_n = cnt_n + 1'b1;
      if (cnt_n == CNT_W'(WORDS)) begin
        valid_n = 1'b1;
        last_n  = wr_top_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_q   <= '0;
      cnt_q   <= '0;
      valid_q <= 1'b0;
      last_q  <= 1'b0;
    end else begin
      buf_q   <= buf_n;
      cnt_q   <= cnt_n;
      valid_q <= valid_n;
      last_q  <= last_n;
    end
  end

  assign blk_data_o  = buf_q;
  assign blk_last_o  = last_q;
  assign blk_valid_o = valid_q;
  assign stall_o     = valid_q && !blk_ready_i;

  AST_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(WORDS)); // R2
  AST_VALID_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q && !blk_ready_i |=> valid_q && $stable(buf_q) && $stable(last_q)); // R3
  AST_VALID_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_q) |-> $past(wr_en_i)); // R3
  AST_NO_LOST_WORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |-> !(valid_q && !blk_ready_i)); // R5
  AST_LAST_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_q) |-> (last_q == $past(wr_top_i))); // R4
endmodule

// File: rtl/cfg_const_src.sv
module cfg_const_src #(
  parameter int unsigned SIZE_W   = 64,
  parameter int unsigned SIZE_VAL = 512,
  parameter int unsigned SCHEME_W = 2
) (
  output logic [SIZE_W-1:0]   cfg_size_o,
  output logic [SCHEME_W-1:0] cfg_scheme_o,
  output logic                cfg_last_o,
  output logic                cfg_valid_o
);
  assign cfg_size_o   = SIZE_W'(SIZE_VAL);
  assign cfg_scheme_o = '0;
  assign cfg_last_o   = 1'b1;
  assign cfg_valid_o  = 1'b1;
endmodule

// File: rtl/ahb_block_packer.sv
module ahb_block_packer
  import blkpack_pkg::*;
#(
  parameter int unsigned ADDR_W   = DEF_ADDR_W,
  parameter int unsigned DATA_W   = DEF_DATA_W,
  parameter int unsigned BLK_W    = DEF_BLK_W,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 32'h6001_0000,
  parameter logic [ADDR_W-1:0] WIN_BYTES = 32'h0000_0800,
  parameter int unsigned CFG_SIZE_W   = 64,
  parameter int unsigned CFG_SCHEME_W = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    hsel_i,
  input  logic [ADDR_W-1:0]       haddr_i,
  input  logic [1:0]              htrans_i,
  input  logic                    hwrite_i,
  input  logic [2:0]              hsize_i,
  input  logic [DATA_W-1:0]       hwdata_i,
  input  logic                    hready_i,
  output logic                    hreadyout_o,
  output logic                    hresp_o,
  output logic [DATA_W-1:0]       hrdata_o,
  output logic [BLK_W-1:0]        blk_data_o,
  output logic                    blk_last_o,
  output logic                    blk_valid_o,
  input  logic                    blk_ready_i,
  output logic [CFG_SIZE_W-1:0]   cfg_size_o,
  output logic [CFG_SCHEME_W-1:0] cfg_scheme_o,
  output logic                    cfg_last_o,
  output logic                    cfg_valid_o
);
  logic wr_en, wr_top, stall;

  ahb_wr_front #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BASE_ADDR(BASE_ADDR), .WIN_BYTES(WIN_BYTES)
  ) u_front (
    .clk_i, .rst_ni, .hsel_i, .haddr_i, .htrans_i, .hwrite_i, .hsize_i, .hready_i,
    .stall_i(stall), .hreadyout_o, .wr_en_o(wr_en), .wr_top_o(wr_top)
  );

  blk_word_packer #(.DATA_W(DATA_W), .BLK_W(BLK_W)) u_pack (
    .clk_i, .rst_ni, .wr_en_i(wr_en), .wr_top_i(wr_top), .wr_data_i(hwdata_i),
    .blk_ready_i, .blk_data_o, .blk_last_o, .blk_valid_o, .stall_o(stall)
  );

  cfg_const_src #(.SIZE_W(CFG_SIZE_W), .SIZE_VAL(BLK_W), .SCHEME_W(CFG_SCHEME_W)) u_cfg (
    .cfg_size_o, .cfg_scheme_o, .cfg_last_o, .cfg_valid_o
  );

  assign hresp_o  = 1'b0;
  assign hrdata_o = '0;

  AST_STALL_WAIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hreadyout_o |-> blk_valid_o && !blk_ready_i); // R5
endmodule

// File: tb/ahb_block_packer_bench.sv
`timescale 1ns/1ps
module ahb_block_packer_bench;
  localparam logic [31:0] BASE = 32'h6001_0000;

  logic clk = 0, rst_n = 0;
  logic hsel = 0, hwrite = 0, blk_ready = 0;
  logic [31:0] haddr = '0, hwdata = '0;
  logic [1:0] htrans = 2'b00;
  logic [2:0] hsize = 3'd2;
  logic hreadyout, hresp, blk_last, blk_valid, cfg_last, cfg_valid;
  logic [31:0] hrdata;
  logic [511:0] blk_data;
  logic [63:0] cfg_size;
  logic [1:0] cfg_scheme;
  int total = 0, bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  ahb_block_packer u_ahb_block_packer (
    .clk_i(clk), .rst_ni(rst_n), .hsel_i(hsel), .haddr_i(haddr), .htrans_i(htrans),
    .hwrite_i(hwrite), .hsize_i(hsize), .hwdata_i(hwdata), .hready_i(hreadyout),
    .hreadyout_o(hreadyout), .hresp_o(hresp), .hrdata_o(hrdata),
    .blk_data_o(blk_data), .blk_last_o(blk_last), .blk_valid_o(blk_valid),
    .blk_ready_i(blk_ready), .cfg_size_o(cfg_size), .cfg_scheme_o(cfg_scheme),
    .cfg_last_o(cfg_last), .cfg_valid_o(cfg_valid)
  );

  task automatic chk(input string req, input logic [511:0] act, input logic [511:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [511:0] exp_blk(input logic [31:0] seed);
    logic [511:0] r;
    for (int k = 0; k < 16; k++) r[511-32*k -: 32] = seed + 32'(k);
    return r;
  endfunction

  // pipelined NONSEQ/SEQ writes of n words, data seed+k
  task automatic burst(input logic [31:0] a0, input int n, input logic [31:0] seed);
    for (int k = 0; k <= n; k++) begin
      if (k < n) begin
        hsel = 1; hwrite = 1; hsize = 3'd2; haddr = a0 + 32'(4*k);
        htrans = (k == 0) ? 2'b10 : 2'b11;
      end else begin
        hsel = 0; htrans = 2'b00;
      end
      if (k > 0) hwdata = seed + 32'(k - 1);
      while (!hreadyout) @(negedge clk);
      @(negedge clk);
    end
  endtask

  task automatic xfer(input logic [31:0] a, input logic [31:0] d, input logic wr,
                      input logic [2:0] sz, input logic [1:0] tr, input logic sel);
    hsel = sel; haddr = a; hwrite = wr; hsize = sz; htrans = tr;
    while (!hreadyout) @(negedge clk);
    @(negedge clk);
    hsel = 0; htrans = 2'b00; hwdata = d;
    while (!hreadyout) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic take_block();
    blk_ready = 1;
    @(negedge clk);
    blk_ready = 0;
    chk("R3 valid low after handshake", 512'(blk_valid), 512'(0));
  endtask

  task automatic t_reset();
    chk("R1 hreadyout", 512'(hreadyout), 512'(1));
    chk("R1 hresp", 512'(hresp), 512'(0));
    chk("R1 valid", 512'(blk_valid), 512'(0));
    chk("R8 size", 512'(cfg_size), 512'(512));
    chk("R8 scheme/last/valid", 512'({cfg_scheme, cfg_last, cfg_valid}), 512'(3'b011));
  endtask

  task automatic t_single_packet();
    burst(BASE + 32'h7C0, 15, 32'hA000_0000);
    chk("R3 valid low before 16th word", 512'(blk_valid), 512'(0));
    burst(BASE + 32'h7FC, 1, 32'hA000_000F);
    chk("R3 valid after 16th word", 512'(blk_valid), 512'(1));
    chk("R2 lanes", blk_data, exp_blk(32'hA000_0000));
    chk("R4 last on top word", 512'(blk_last), 512'(1));
    @(negedge clk);
    chk("R3 hold", blk_data, exp_blk(32'hA000_0000));
    take_block();
  endtask

  task automatic t_stall_two_blocks();
    burst(BASE + 32'h780, 16, 32'hB100_0000);
    chk("R4 first block not last", 512'(blk_last), 512'(0));
    chk("R2 first block", blk_data, exp_blk(32'hB100_0000));
    hsel = 1; hwrite = 1; hsize = 3'd2; haddr = BASE + 32'h7C0; htrans = 2'b10;
    @(negedge clk);
    hsel = 0; htrans = 2'b00; hwdata = 32'hB200_0000;
    chk("R5 stall", 512'(hreadyout), 512'(0));
    @(negedge clk);
    chk("R5 still stalled", 512'(hreadyout), 512'(0));
    chk("R3 data held in stall", blk_data, exp_blk(32'hB100_0000));
    take_block();
    chk("R5 released", 512'(hreadyout), 512'(1));
    burst(BASE + 32'h7C4, 15, 32'hB200_0001);
    chk("R5 stalled word kept", blk_data, exp_blk(32'hB200_0000));
    chk("R4 second block last", 512'(blk_last), 512'(1));
    take_block();
  endtask

  task automatic t_read();
    burst(BASE, 15, 32'hC000_0000);
    hsel = 1; hwrite = 0; hsize = 3'd2; haddr = BASE + 32'h3C; htrans = 2'b10;
    @(negedge clk);
    hsel = 0; htrans = 2'b00;
    chk("R6 read data/resp/ready", 512'({hrdata, hresp, hreadyout}), 512'({32'h0, 1'b0, 1'b1}));
    @(negedge clk);
    chk("R6 read not counted", 512'(blk_valid), 512'(0));
    xfer(BASE + 32'h3C, 32'hC000_000F, 1, 3'd2, 2'b10, 1);
    chk("R6 block after read", blk_data, exp_blk(32'hC000_0000));
    chk("R4 not last off-top", 512'(blk_last), 512'(0));
    take_block();
  endtask

  task automatic t_ignored();
    burst(BASE + 32'h40, 15, 32'hD000_0000);
    xfer(BASE + 32'h7C, 32'hDEAD_0001, 1, 3'd0, 2'b10, 1);
    xfer(BASE + 32'h7C, 32'hDEAD_0002, 1, 3'd1, 2'b11, 1);
    xfer(BASE + 32'h800, 32'hDEAD_0003, 1, 3'd2, 2'b10, 1);
    xfer(BASE - 32'h4, 32'hDEAD_0004, 1, 3'd2, 2'b10, 1);
    xfer(BASE + 32'h7E, 32'hDEAD_0005, 1, 3'd2, 2'b10, 1);
    xfer(BASE + 32'h7C, 32'hDEAD_0006, 1, 3'd2, 2'b01, 1);
    xfer(BASE + 32'h7C, 32'hDEAD_0007, 1, 3'd2, 2'b00, 1);
    xfer(BASE + 32'h7C, 32'hDEAD_0008, 1, 3'd2, 2'b10, 0);
    chk("R7 ignored writes not counted", 512'(blk_valid), 512'(0));
    xfer(BASE + 32'h7C, 32'hD000_000F, 1, 3'd2, 2'b10, 1);
    chk("R7 valid after real 16th", 512'(blk_valid), 512'(1));
    chk("R7 no ignored data in block", blk_data, exp_blk(32'hD000_0000));
    take_block();
  endtask

  initial begin
    #1000000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_single_packet();
    t_stall_two_blocks();
    t_read();
    t_ignored();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule